// File: doc/BRIEF.md
# Interrupt Restart Vector Controller

This block decides which pending interrupt the core services next and gives the program counter sequencer the restart address for it. It has five sources. The trap line and the high-priority line latch a rising edge. The mid-priority and low-priority lines are level requests. The fifth source is an external restart request that carries a 3-bit slot number. A single interrupt-enable flag gates every source except the trap. The core's enable and disable commands write that flag. Reset clears it, and so does every accepted interrupt.

The vector leaves the block on a valid/ready handshake. `vec_valid_o` is high while an eligible request exists, and `vec_addr_o` names the winner. The sequencer raises `vec_ready_i` at an instruction boundary. An interrupt is accepted in a cycle where valid and ready are both high. In that cycle `ack_o` pulses and the address on `vec_addr_o` is the one taken. While ready is low, an edge-latched request waits without limit. The offered address can still change before acceptance when a higher-priority request arrives, or when a level request or the enable flag drops. The block also records the halted state of the core. The halt command sets it, and only an accepted interrupt or reset clears it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The fixed vectors are 0x0024 for the trap, 0x003C for the high line, 0x0034 for the mid line and 0x002C for the low line.
- R2: An external restart request with `ext_num_i` = n offers the vector n*8 (n from 0 to 7).
- R3: `ie_o` is set one cycle after `ei_cmd_i` and cleared one cycle after `di_cmd_i`. If both commands arrive in the same cycle, disable wins. Reset clears `ie_o`.
- R4: While `ie_o` is low, the high, mid, low and external requests cannot raise `vec_valid_o`. The trap still can.
- R5: An acceptance (`vec_valid_o` and `vec_ready_i` both high) clears `ie_o` on the next cycle. This holds even when `ei_cmd_i` is high in the same cycle.
- R6: When several requests are eligible, the winner is chosen in this order: trap, then high, then mid, then low, then external restart.
- R7: A rising edge on the trap or the high line is held pending until that source is accepted. Holding either line high afterwards does not raise a new request. The mid, low and external requests follow their input levels.
- R8: `halted_o` goes high one cycle after `halt_cmd_i`. It stays high through enable commands and unaccepted requests, and it clears one cycle after an acceptance. An acceptance in the same cycle as a halt command leaves `halted_o` low.
- R9: `ack_o` is high exactly in the cycles of acceptance, and `vec_addr_o` carries the accepted vector in that cycle. Without ready, a pending edge request stays offered.
- R10: After reset, `vec_valid_o`, `ack_o`, `ie_o` and `halted_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Trap line, edge latched, never masked |
| irq_hi_i | input | 1 | High-priority line, edge latched |
| irq_mid_i | input | 1 | Mid-priority line, level |
| irq_lo_i | input | 1 | Low-priority line, level |
| ext_req_i | input | 1 | External restart request, level |
| ext_num_i | input | 3 | Slot number of the external restart |
| ei_cmd_i | input | 1 | Enable-interrupts command |
| di_cmd_i | input | 1 | Disable-interrupts command |
| halt_cmd_i | input | 1 | Core enters halt |
| vec_ready_i | input | 1 | Sequencer ready to take a vector |
| vec_valid_o | output | 1 | A vector is offered |
| vec_addr_o | output | 16 | Offered restart address |
| ack_o | output | 1 | Acceptance pulse |
| ie_o | output | 1 | Interrupt-enable flag |
| halted_o | output | 1 | Core is halted |

## Verification
Two functions can fall in the same cycle. The first is an acceptance together with an enable command. The bench provokes it by keeping ready high while it pulses `ei_cmd_i` with an external request already present, and it judges the result by `ie_o` reading low afterwards. The second is an acceptance together with a halt command. The bench pulses `halt_cmd_i` in the very cycle an acceptance happens and requires `halted_o` to stay low. In both cases a scoreboard pairs each acknowledge with the vector that the requirements predict.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NSRC = 5;

  typedef enum logic [2:0] {
    SRC_TRAP = 3'd0,
    SRC_HI   = 3'd1,
    SRC_MID  = 3'd2,
    SRC_LO   = 3'd3,
    SRC_EXT  = 3'd4
  } ivc_src_e;

  // byte address of each fixed restart slot
  function automatic logic [7:0] fixed_vec(input int unsigned idx);
    case (idx)
      0:       fixed_vec = 8'h24;
      1:       fixed_vec = 8'h3C;
      2:       fixed_vec = 8'h34;
      3:       fixed_vec = 8'h2C;
      default: fixed_vec = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ivc_edge_pend.sv
module ivc_edge_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clr_i,
  output logic pend_o
);
  logic line_q;
  logic pend_q;
  logic rise;

  assign rise = line_i & ~line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      line_q <= line_i;
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  assign pend_o = pend_q;

  assert_edge_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_i && !line_q) |=> pend_o);
  assert_held_level_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && line_q && line_i) |=> !pend_o);
endmodule

// File: rtl/ivc_prio_sel.sv
module ivc_prio_sel #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         valid_o
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]    = req_i[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | req_i[i];
  end
  assign valid_o = taken[N];

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  assert_first_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[0] |-> gnt_o[0]);
endmodule

// File: rtl/ivc_ctrl_state.sv
module ivc_ctrl_state (
  input  logic clk,
  input  logic rst_n,
  input  logic ei_i,
  input  logic di_i,
  input  logic halt_i,
  input  logic accept_i,
  output logic ie_o,
  output logic halted_o
);
  logic ie_q, halted_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      if (accept_i || di_i) ie_q <= 1'b0;
      else if (ei_i)        ie_q <= 1'b1;
      if (accept_i)         halted_q <= 1'b0;
      else if (halt_i)      halted_q <= 1'b1;
    end
  end

  assign ie_o     = ie_q;
  assign halted_o = halted_q;

  assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    di_i |=> !ie_o);
  assert_halt_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !halted_o);
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !accept_i) |=> halted_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int ADDR_W = 16,
  parameter int NUM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              irq_hi_i,
  input  logic              irq_mid_i,
  input  logic              irq_lo_i,
  input  logic              ext_req_i,
  input  logic [NUM_W-1:0]  ext_num_i,
  input  logic              ei_cmd_i,
  input  logic              di_cmd_i,
  input  logic              halt_cmd_i,
  input  logic              vec_ready_i,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              ack_o,
  output logic              ie_o,
  output logic              halted_o
);
  import ivc_pkg::*;

  localparam int SLOT_SHIFT = 3;

  logic            ie;
  logic            trap_pend, hi_pend;
  logic [NSRC-1:0] req, gnt;
  logic            valid, accept;

  ivc_edge_pend u_trap (
    .clk(clk), .rst_n(rst_n), .line_i(trap_i),
    .clr_i(accept & gnt[SRC_TRAP]), .pend_o(trap_pend)
  );

  ivc_edge_pend u_hi (
    .clk(clk), .rst_n(rst_n), .line_i(irq_hi_i),
    .clr_i(accept & gnt[SRC_HI]), .pend_o(hi_pend)
  );

  assign req[SRC_TRAP] = trap_pend;
  assign req[SRC_HI]   = hi_pend   & ie;
  assign req[SRC_MID]  = irq_mid_i & ie;
  assign req[SRC_LO]   = irq_lo_i  & ie;
  assign req[SRC_EXT]  = ext_req_i & ie;

  ivc_prio_sel #(.N(NSRC)) u_sel (
    .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt), .valid_o(valid)
  );

  assign accept = valid & vec_ready_i;

  always_comb begin
    vec_addr_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (gnt[i]) begin
        if (i == int'(SRC_EXT))
          vec_addr_o = ADDR_W'({ext_num_i, {SLOT_SHIFT{1'b0}}});
        else
          vec_addr_o = ADDR_W'(fixed_vec(i));
      end
    end
  end

  ivc_ctrl_state u_state (
    .clk(clk), .rst_n(rst_n), .ei_i(ei_cmd_i), .di_i(di_cmd_i),
    .halt_i(halt_cmd_i), .accept_i(accept), .ie_o(ie), .halted_o(halted_o)
  );

  assign vec_valid_o = valid;
  assign ack_o       = accept;
  assign ie_o        = ie;

  assert_ack_clears_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ie_o);
  assert_masked_only_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_o && vec_valid_o) |-> (vec_addr_o == ADDR_W'(16'h0024)));
  assert_ack_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (vec_valid_o && vec_ready_i));
  assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pend && !ack_o) |=> vec_valid_o);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_i = 0, irq_hi_i = 0, irq_mid_i = 0, irq_lo_i = 0, ext_req_i = 0;
  logic [2:0] ext_num_i = 0;
  logic ei_cmd_i = 0, di_cmd_i = 0, halt_cmd_i = 0, vec_ready_i = 0;
  logic vec_valid_o, ack_o, ie_o, halted_o;
  logic [15:0] vec_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .irq_hi_i(irq_hi_i),
    .irq_mid_i(irq_mid_i), .irq_lo_i(irq_lo_i), .ext_req_i(ext_req_i),
    .ext_num_i(ext_num_i), .ei_cmd_i(ei_cmd_i), .di_cmd_i(di_cmd_i),
    .halt_cmd_i(halt_cmd_i), .vec_ready_i(vec_ready_i),
    .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o), .ack_o(ack_o),
    .ie_o(ie_o), .halted_o(halted_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every acknowledge must match the next expected vector
  always @(negedge clk) begin
    if (rst_n && ack_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected ack actual=%0h expected=none", vec_addr_o);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {16'h0, vec_addr_o}, {16'h0, e});
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_ei();
    step(); ei_cmd_i = 1; step(); ei_cmd_i = 0;
  endtask

  // one cycle of ready; expects exactly one acknowledge with this vector
  task automatic grant(input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    step(); vec_ready_i = 1; step(); vec_ready_i = 0;
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) step();
    look();
    check("R10 valid", vec_valid_o, 0);
    check("R10 ie", ie_o, 0);
    check("R10 halted", halted_o, 0);
    check("R10 ack", ack_o, 0);
    step(); rst_n = 1;

    // R4: masked low line
    vec_ready_i = 1; irq_lo_i = 1; ext_req_i = 1;
    step(); step(); look();
    check("R4 masked valid", vec_valid_o, 0);
    step(); vec_ready_i = 0; irq_lo_i = 0; ext_req_i = 0;

    // R3
    pulse_ei(); look(); check("R3 ei sets", ie_o, 1);
    step(); di_cmd_i = 1; step(); di_cmd_i = 0; look(); check("R3 di clears", ie_o, 0);
    step(); ei_cmd_i = 1; di_cmd_i = 1; step(); ei_cmd_i = 0; di_cmd_i = 0;
    look(); check("R3 di wins", ie_o, 0);

    // R1/R6 ordering
    pulse_ei(); irq_lo_i = 1; irq_mid_i = 1; ext_req_i = 1; ext_num_i = 3'd7;
    step(); irq_hi_i = 1; step(); irq_hi_i = 0;
    step(); look();
    check("R1 R6 hi vector", vec_addr_o, 16'h003C);
    check("R9 held without ready", vec_valid_o, 1);
    grant(16'h003C, "R1 hi ack");
    look(); check("R5 ie after ack", ie_o, 0);
    check("R4 masked after ack", vec_valid_o, 0);
    pulse_ei(); look(); check("R1 R6 mid vector", vec_addr_o, 16'h0034);
    grant(16'h0034, "R1 mid ack");
    irq_mid_i = 0; pulse_ei(); look(); check("R1 R6 lo vector", vec_addr_o, 16'h002C);
    grant(16'h002C, "R1 lo ack");
    irq_lo_i = 0; pulse_ei(); look(); check("R6 ext last", vec_addr_o, 16'h0038);
    grant(16'h0038, "R2 ext7 ack");
    ext_req_i = 0;

    // R7: held high line does not retrigger
    irq_hi_i = 1; step(); step(); pulse_ei(); look();
    check("R7 hi rise", vec_addr_o, 16'h003C);
    grant(16'h003C, "R7 hi ack");
    pulse_ei(); step(); look();
    check("R7 held hi no retrigger", vec_valid_o, 0);
    irq_hi_i = 0; step(); di_cmd_i = 1; step(); di_cmd_i = 0;

    // R2: every slot
    for (int n = 0; n < 8; n++) begin
      pulse_ei(); ext_req_i = 1; ext_num_i = 3'(n);
      look(); check($sformatf("R2 ext slot %0d", n), vec_addr_o, 32'(n * 8));
      grant(16'(n * 8), "R2 ext ack");
      ext_req_i = 0;
    end

    // R7/R4: trap pulse while masked, latched
    step(); trap_i = 1; step(); trap_i = 0; step(); step(); look();
    check("R4 trap unmasked", vec_valid_o, 1);
    check("R1 trap vector", vec_addr_o, 16'h0024);
    grant(16'h0024, "R1 trap ack");
    look(); check("R7 trap cleared", vec_valid_o, 0);
    // trap over external
    pulse_ei(); ext_req_i = 1; ext_num_i = 3'd2;
    step(); trap_i = 1; step(); look();
    check("R6 trap over ext", vec_addr_o, 16'h0024);
    grant(16'h0024, "R6 trap ack");
    look(); check("R7 trap held no retrigger", vec_valid_o, 0);
    trap_i = 0; ext_req_i = 0;

    // R5 collision: ei in acceptance cycle
    pulse_ei(); ext_req_i = 1; ext_num_i = 3'd5;
    exp_q.push_back(16'h0028); tag_q.push_back("R5 collision ack");
    step(); vec_ready_i = 1; ei_cmd_i = 1; step(); vec_ready_i = 0; ei_cmd_i = 0;
    look(); check("R5 ack beats ei", ie_o, 0);
    ext_req_i = 0;

    // R8 halt
    step(); halt_cmd_i = 1; step(); halt_cmd_i = 0; look();
    check("R8 halted set", halted_o, 1);
    pulse_ei(); step(); look(); check("R8 halted through ei", halted_o, 1);
    ext_req_i = 1; ext_num_i = 3'd1; look();
    check("R8 halted while pending", halted_o, 1);
    grant(16'h0008, "R8 release ack");
    look(); check("R8 released", halted_o, 0);
    ext_req_i = 0;
    pulse_ei(); ext_req_i = 1; ext_num_i = 3'd4;
    exp_q.push_back(16'h0020); tag_q.push_back("R8 collision ack");
    step(); vec_ready_i = 1; halt_cmd_i = 1; step(); vec_ready_i = 0; halt_cmd_i = 0;
    look(); check("R8 ack beats halt", halted_o, 0);
    ext_req_i = 0;

    repeat (3) step();
    check("R9 all acks seen", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule